// File: doc/BRIEF.md
# Flow-through no-turnaround synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static memory. Its word is made of four lanes of nine bits each (eight data bits and one parity bit). Every address, data and control input except output enable, sleep and the burst-order tie-off is taken on the rising clock edge. Reads are flow-through. The registered address drives the array combinationally, so read data appears in the same cycle as the edge that took the read command.

Writes are delayed by one edge. The edge that takes a write command holds its address as pending. The data word and the lane write enables are taken on the next enabled edge, and the word is committed to the array on that same edge. Reads and writes can therefore follow one another in any order with no idle cycle. A read issued directly after a write sees the new data.

An advance/load input either loads a fresh address or steps a two-bit burst counter. The counter steps through the two lowest address bits in interleaved or linear order, selected by a static tie-off. Clock enable suspends the device. A sleep input and an output enable gate the data drivers asynchronously. The drivers are modelled as a data bus plus a drive-enable flag, and the data bus reads zero whenever it is not driven.

Top module: `ftsram_top`

## Requirements
- R1: On an enabled rising edge (cke high, sleep low), a selected load (adv low) with write_n high starts a read of addr. After that edge and before the next one, dout_en is 1 and dout holds the word stored at the addressed location. No extra pipeline register sits between the array and dout.
- R2: While cke is low, rising edges are ignored. No state changes, no write data is taken, and dout/dout_en keep their values.
- R3: A selected load with write_n low registers a write address. On the next enabled edge, din is written to that address, lane by lane. Lane i is bits [9*i+8:9*i] and is written only when lane_we_n[i] is 0.
- R4: The device is selected only when sel_a=1, sel_b=1 and sel_n=0. A load taken with any other combination deselects the device: it does not write and does not drive.
- R5: With adv high, an active operation advances its burst counter by one beat and keeps its read/write type. With adv high and the device idle, it stays idle.
- R6: The burst address keeps the upper address bits of the load. Its two low bits are base^beat when seq_linear=0, and (base+beat) mod 4 when seq_linear=1. The beat count wraps after four beats.
- R7: Reads and writes can be issued on consecutive edges with no idle cycle. A read of the address written by the preceding command returns the newly written lanes.
- R8: oe_n high forces dout_en to 0 (and dout to 0) at once, with no clock edge needed.
- R9: sleep high forces dout_en to 0 at once, and every edge is ignored while sleep is high. Internal state is held.
- R10: After reset, the device is idle and dout_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | input | 1 | Clock enable, active high |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_n | input | 1 | Chip select, active low |
| write_n | input | 1 | 0 = write command, 1 = read command (at load) |
| adv | input | 1 | 1 = advance burst, 0 = load new address |
| addr | input | ADDR_W | Word address; its two low bits seed the burst |
| lane_we_n | input | LANES | Per-lane write enable, active low, taken with the data |
| din | input | LANES*LANE_W | Write data, one edge after its address |
| seq_linear | input | 1 | Static burst order: 0 interleaved, 1 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down, active high |
| dout | output | LANES*LANE_W | Read data (0 when not driven) |
| dout_en | output | 1 | Data bus drive enable |

## Verification
Two functions can fall on one edge: the commit of a pending write's data and the registration of the next command. When that next command is a read of the same word, it must return the just-written lanes. The bench provokes this by writing all sixteen words back to back, each data beat sharing its edge with the next address. It then issues write-then-read pairs to one word under every lane mask, and runs write bursts that end in an immediate read burst. Each cycle's dout is judged against a bench-side memory that applies the lane mask arithmetically. The burst address of every beat is recomputed from the seed, the beat and the order.

// File: rtl/ftsram_pkg.sv
package ftsram_pkg;

  // Two-bit burst sequence: interleaved XOR or linear increment modulo 4
  function automatic logic [1:0] burst_low(input logic [1:0] seed,
                                           input logic [1:0] beat,
                                           input logic       linear);
    burst_low = linear ? (seed + beat) : (seed ^ beat);
  endfunction

endpackage

// File: rtl/ftsram_rst_sync.sv
module ftsram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/ftsram_ctrl.sv
module ftsram_ctrl
  import ftsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              load,
  input  logic              selected,
  input  logic              is_write_cmd,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              linear,
  output logic              active,
  output logic              is_write,
  output logic [ADDR_W-1:0] cur_addr
);

  logic              act_q, act_d;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        beat_q, beat_d;

  always_comb begin
    act_d  = act_q;
    wr_d   = wr_q;
    base_d = base_q;
    beat_d = beat_q;
    if (go) begin
      if (load) begin
        act_d = selected;
        if (selected) begin
          wr_d   = is_write_cmd;
          base_d = addr_in;
          beat_d = 2'd0;
        end
      end else if (act_q) begin
        beat_d = beat_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      beat_q <= 2'd0;
    end else if (go) begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      base_q <= base_d;
      beat_q <= beat_d;
    end
  end

  assign active   = act_q;
  assign is_write = wr_q;
  assign cur_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], beat_q, linear)};

  // R2: a suspended edge changes nothing
  a_r2_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> ($stable(act_q) && $stable(base_q) && $stable(beat_q) && $stable(wr_q)));

  // R4: a load without valid selects leaves the device idle
  a_r4_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (go && load && !selected) |=> !act_q);

  // R5: advancing an active operation steps the beat and keeps its type
  a_r5_advance_step: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !load && act_q) |=> (beat_q == $past(beat_q) + 2'd1) && $stable(wr_q));

  // R6: upper address bits fixed across a burst
  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !load) |=> $stable(cur_addr[ADDR_W-1:2]));

endmodule

// File: rtl/ftsram_array.sv
module ftsram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    commit,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        lane_wen,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
      if (commit && lane_wen[g]) mem_q[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem_q[addr];
  end

endmodule

// File: rtl/ftsram_top.sv
module ftsram_top #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke,
  input  logic                    sel_a,
  input  logic                    sel_b,
  input  logic                    sel_n,
  input  logic                    write_n,
  input  logic                    adv,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    seq_linear,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);

  localparam int DW = LANES * LANE_W;

  logic              rst_s_n;
  logic              go, selected, active, is_write, commit;
  logic [ADDR_W-1:0] cur_addr;
  logic [DW-1:0]     rd_data;

  assign go       = cke & ~sleep;
  assign selected = sel_a & sel_b & ~sel_n;
  assign commit   = go & active & is_write;

  ftsram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  ftsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .go           (go),
    .load         (~adv),
    .selected     (selected),
    .is_write_cmd (~write_n),
    .addr_in      (addr),
    .linear       (seq_linear),
    .active       (active),
    .is_write     (is_write),
    .cur_addr     (cur_addr)
  );

  ftsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk      (clk),
    .commit   (commit),
    .addr     (cur_addr),
    .wdata    (din),
    .lane_wen (~lane_we_n),
    .rdata    (rd_data)
  );

  assign dout_en = active & ~is_write & ~oe_n & ~sleep;
  assign dout    = dout_en ? rd_data : '0;

  // R8 / R9: disabled drivers whenever output enable is off or asleep
  a_r8_oe_hiz: assert property (@(posedge clk) disable iff (!rst_s_n)
    (oe_n || sleep) |-> (!dout_en && dout == '0));

  // R9: a sleeping edge leaves the burst address unchanged
  a_r9_sleep_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    sleep |=> $stable(cur_addr));

  // R3: no lane is written while suspended
  a_r3_no_commit_suspend: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cke |-> !commit);

endmodule

// File: tb/ftsram_top_bench.sv
module ftsram_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 1'b0;
  logic rst_n, cke, sel_a, sel_b, sel_n, write_n, adv, seq_linear, oe_n, sleep;
  logic [AW-1:0] addr;
  logic [NL-1:0] lane_we_n;
  logic [DW-1:0] din, dout;
  logic          dout_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  ftsram_top #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_ftsram_top (
    .clk(clk), .rst_n(rst_n), .cke(cke), .sel_a(sel_a), .sel_b(sel_b),
    .sel_n(sel_n), .write_n(write_n), .adv(adv), .addr(addr),
    .lane_we_n(lane_we_n), .din(din), .seq_linear(seq_linear), .oe_n(oe_n),
    .sleep(sleep), .dout(dout), .dout_en(dout_en)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string tag = "R10";

  // bench reference state, built from the requirements
  logic          m_act, m_wr;
  logic [AW-1:0] m_base;
  logic [1:0]    m_beat;
  logic [DW-1:0] mem_m [1<<AW];

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] lo;
    lo = seq_linear ? (m_base[1:0] + m_beat) : (m_base[1:0] ^ m_beat);
    return {m_base[AW-1:2], lo};
  endfunction

  function automatic logic [DW-1:0] pat(input int k);
    return DW'(64'h9_1A2B_3C4D) ^ DW'(k * 36'h0_7E5_3C1) ^ DW'(k << 20);
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_out();
    logic en_e;
    en_e = m_act && !m_wr && !oe_n && !sleep;
    chk(tag, DW'(dout_en), DW'(en_e));
    if (en_e) chk(tag, dout, mem_m[m_addr()]);
  endtask

  task automatic step();
    if (cke && !sleep && rst_n) begin
      if (m_act && m_wr)
        for (int l = 0; l < NL; l++)
          if (!lane_we_n[l]) mem_m[m_addr()][l*LW +: LW] = din[l*LW +: LW];
      if (!adv) begin
        m_act = sel_a && sel_b && !sel_n;
        if (m_act) begin
          m_wr = !write_n; m_base = addr; m_beat = 2'd0;
        end
      end else if (m_act) m_beat = m_beat + 2'd1;
    end
    @(posedge clk); #1;
    check_out();
  endtask

  task automatic cmd(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    adv = 1'b0; write_n = !wr; addr = a; din = d;
    sel_a = 1'b1; sel_b = 1'b1; sel_n = 1'b0;
    step();
  endtask

  task automatic desel(input logic [DW-1:0] d);
    adv = 1'b0; sel_a = 1'b0; din = d; step();
    sel_a = 1'b1;
  endtask

  task automatic advance(input logic [DW-1:0] d);
    adv = 1'b1; din = d; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; sel_a = 1'b0; sel_b = 1'b1; sel_n = 1'b0;
    write_n = 1'b1; adv = 1'b0; addr = '0; lane_we_n = '0; din = '0;
    seq_linear = 1'b0; oe_n = 1'b0; sleep = 1'b0;
    m_act = 1'b0; m_wr = 1'b0; m_base = '0; m_beat = 2'd0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tag = "R10 reset idle";
    repeat (3) step();
    chk("R10 dout_en after reset", DW'(dout_en), DW'(0));

    // R7: back-to-back writes, each data beat shares its edge with the next address
    tag = "R7 back-to-back write";
    for (int a = 0; a < 16; a++) cmd(1'b1, AW'(a), (a == 0) ? '0 : pat(a - 1));
    desel(pat(15));
    // R1: flow-through reads, one per cycle
    tag = "R1 flow-through read";
    for (int a = 0; a < 16; a++) begin
      cmd(1'b0, AW'(a), '0);
      chk("R1 read word", dout, pat(a));
    end

    // R7: write then immediate read of the same word
    tag = "R7 write-read turn";
    for (int a = 0; a < 16; a += 5) begin
      cmd(1'b1, AW'(a), '0);
      cmd(1'b0, AW'(a), pat(a + 50));
      chk("R7 read after write", dout, pat(a + 50));
    end

    // R3: every lane mask
    tag = "R3 lane mask";
    for (int m = 0; m < 16; m++) begin
      lane_we_n = NL'(m);
      cmd(1'b1, AW'(3), '0);
      cmd(1'b0, AW'(3), pat(m + 100));
    end
    lane_we_n = '0;

    // R6: read bursts in both orders from every seed, including wrap
    for (int lin = 0; lin < 2; lin++) begin
      seq_linear = lin[0];
      tag = lin ? "R6 linear burst" : "R6 interleaved burst";
      for (int s = 0; s < 4; s++) begin
        cmd(1'b0, AW'(8 + s), '0);
        for (int b = 0; b < 5; b++) advance('0);
      end
      // write burst then read burst
      tag = "R6 write burst";
      cmd(1'b1, AW'(13), '0);
      for (int b = 0; b < 4; b++) advance(pat(200 + b + 4*lin));
      cmd(1'b0, AW'(13), pat(204 + 4*lin));
      for (int b = 0; b < 3; b++) advance('0);
    end
    seq_linear = 1'b0;

    // R2: suspend holds a read and a pending write
    tag = "R2 suspend";
    cmd(1'b0, AW'(2), '0);
    cke = 1'b0; cmd(1'b0, AW'(7), '0);
    chk("R2 held read", dout, mem_m[2]);
    cke = 1'b1;
    cmd(1'b1, AW'(6), '0);
    cke = 1'b0; desel(pat(999));
    cke = 1'b1; desel(pat(300));
    cmd(1'b0, AW'(6), '0);
    chk("R2 data taken after suspend", dout, pat(300));

    // R4: each select alone invalid
    tag = "R4 select";
    for (int k = 0; k < 3; k++) begin
      adv = 1'b0; write_n = 1'b0; addr = AW'(9); din = '0;
      sel_a = (k != 0); sel_b = (k != 1); sel_n = (k == 2);
      step();
      din = pat(400 + k); sel_a = 1'b0; step();
      chk("R4 deselected drive", DW'(dout_en), DW'(0));
      sel_a = (k != 0); sel_b = (k != 1); sel_n = (k == 2);
      write_n = 1'b1; step();
      chk("R4 deselected read", DW'(dout_en), DW'(0));
      cmd(1'b0, AW'(9), '0);
      chk("R4 word untouched", dout, pat(9));
    end

    // R5: advance while idle stays idle
    tag = "R5 idle advance";
    desel('0);
    for (int b = 0; b < 3; b++) begin
      advance('0);
      chk("R5 idle no drive", DW'(dout_en), DW'(0));
    end

    // R8: output enable acts without a clock edge
    tag = "R8 output enable";
    cmd(1'b0, AW'(4), '0);
    @(negedge clk); oe_n = 1'b1; #1;
    chk("R8 oe off", DW'(dout_en), DW'(0));
    chk("R8 bus zero", dout, '0);
    oe_n = 1'b0; #1;
    chk("R8 oe on", dout, mem_m[4]);

    // R9: sleep gates drivers at once and ignores edges
    tag = "R9 sleep";
    @(negedge clk); sleep = 1'b1; #1;
    chk("R9 sleep off", DW'(dout_en), DW'(0));
    cmd(1'b1, AW'(4), '0);
    desel(pat(500));
    sleep = 1'b0; #1;
    chk("R9 state held", DW'(dout_en), DW'(1));
    chk("R9 word untouched", dout, mem_m[4]);
    chk("R9 model word", mem_m[4], pat(4));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule